// File: doc/BRIEF.md
# Card Response and Status Pin Driver

This block drives three active-low status pins on the card side of a PC Card style I/O card. The first is an input acknowledge, asserted for I/O reads that the card claims. The second reports whether the addressed port accepts 16-bit accesses. The third is an interrupt request. It decodes the card enable, register select and I/O read strobes, and checks the address bus against an I/O window given as a base and a don't-care mask.

After power-up or reset the card runs in memory-interface mode. In this mode the 16-bit indication pin is a write-protect output and the interrupt pin is a ready/busy output, and both are held high. The first write to the configuration register address moves the card to I/O mode. Only a reset brings it back. A separate select turns off address matching when the host decodes I/O addresses independently.

All inputs are synchronous to `clk`. Every pin is registered, so each output follows its inputs by one clock.

Top module: `card_status_pins`

## Requirements
- R1: With independent addressing off, `ack_n` is low one clock after `ce_n`, `reg_n` and `iord_n` are all low and `(addr & ~win_mask) == (win_base & ~win_mask)`. A mask bit of 1 means that address bit is ignored.
- R2: With independent addressing off, `ack_n` stays high while an I/O read addresses a location outside the window.
- R3: With `indep_io` = 1, `ack_n` is low one clock after `ce_n`, `reg_n` and `iord_n` are all low, for any address.
- R4: `ack_n` returns high one clock after any of `ce_n`, `reg_n` or `iord_n` goes high.
- R5: After reset, `io_mode` = 0 and `ack_n`, `port16_n` and `intreq_n` are all high.
- R6: While `io_mode` = 0, `port16_n` (write-protect) and `intreq_n` (ready) stay high whatever `word_ok` and `irq_pending` are.
- R7: `io_mode` goes to 1 after a clock on which `ce_n`, `reg_n` and `we_n` are low and `addr` equals `CFG_ADDR`. A write to any other address leaves it at 0. Once set, it stays at 1 until reset.
- R8: In I/O mode, `port16_n` is low one clock after an access is decoded (as in R1 or R3) while `word_ok` = 1. In all other cases it is high.
- R9: In I/O mode, `intreq_n` equals the inverse of `irq_pending` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Card enable, active low |
| reg_n | input | 1 | Register/attribute space select, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| addr | input | AW | Host address bus |
| win_base | input | AW | I/O window base address |
| win_mask | input | AW | Window don't-care bits (1 = ignored) |
| indep_io | input | 1 | 1 = acknowledge I/O reads without an address check |
| word_ok | input | 1 | 1 = the window accepts word access |
| irq_pending | input | 1 | Internal interrupt pending |
| ack_n | output | 1 | Input acknowledge, active low |
| port16_n | output | 1 | 16-bit port indication in I/O mode, write-protect in memory mode |
| intreq_n | output | 1 | Interrupt request in I/O mode, ready/busy in memory mode |
| io_mode | output | 1 | 1 once the configuration register has been written |

## Verification
The hardest state to reach is the point where the pins change meaning. It only changes once, on a configuration write, and a plain write to any other address must not trigger it. The bench first holds `word_ok` and `irq_pending` active in memory mode and checks that both status pins stay high. Next it writes to a near-miss address and confirms the mode has not changed. Only then does it issue the matching write and check the pins in I/O mode. A write strobe with `iord_n` high is also used to confirm that a configuration write never produces an acknowledge.

// File: rtl/card_status_pins.sv
module card_status_pins #(
  parameter int AW = 10,
  parameter logic [AW-1:0] CFG_ADDR = 10'h200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          reg_n,
  input  logic          iord_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] win_base,
  input  logic [AW-1:0] win_mask,
  input  logic          indep_io,
  input  logic          word_ok,
  input  logic          irq_pending,
  output logic          ack_n,
  output logic          port16_n,
  output logic          intreq_n,
  output logic          io_mode
);

  logic io_rd, in_win, claim, cfg_wr;

  assign io_rd  = !ce_n && !reg_n && !iord_n;
  assign in_win = ((addr ^ win_base) & ~win_mask) == '0;
  assign claim  = io_rd && (indep_io || in_win);
  assign cfg_wr = !ce_n && !reg_n && !we_n && (addr == CFG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_mode  <= 1'b0;
      ack_n    <= 1'b1;
      port16_n <= 1'b1;
      intreq_n <= 1'b1;
    end else begin
      if (cfg_wr) io_mode <= 1'b1;
      ack_n    <= !claim;
      port16_n <= io_mode ? !(claim && word_ok) : 1'b1;
      intreq_n <= io_mode ? !irq_pending : 1'b1;
    end
  end

  a_r2_out_of_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !reg_n && !iord_n && !indep_io &&
     (((addr ^ win_base) & ~win_mask) != '0)) |=> ack_n);

  a_r3_indep_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !reg_n && !iord_n && indep_io) |=> !ack_n);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || reg_n || iord_n) |=> ack_n);

  a_r6_mem_mode_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !io_mode |=> (port16_n && intreq_n));

  a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |=> io_mode);

  a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |=> (intreq_n == !$past(irq_pending)));

endmodule

// File: tb/card_status_pins_test.sv
module card_status_pins_test;
  localparam int AW = 10;
  localparam logic [AW-1:0] CFG = 10'h200;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, reg_n = 1, iord_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0, win_base = 10'h300, win_mask = 10'h01F;
  logic indep_io = 0, word_ok = 0, irq_pending = 0;
  logic ack_n, port16_n, intreq_n, io_mode;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  card_status_pins #(.AW(AW), .CFG_ADDR(CFG)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .reg_n(reg_n), .iord_n(iord_n),
    .we_n(we_n), .addr(addr), .win_base(win_base), .win_mask(win_mask),
    .indep_io(indep_io), .word_ok(word_ok), .irq_pending(irq_pending),
    .ack_n(ack_n), .port16_n(port16_n), .intreq_n(intreq_n), .io_mode(io_mode));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic idle();
    ce_n = 1; reg_n = 1; iord_n = 1; we_n = 1; step();
  endtask

  task automatic io_read(logic [AW-1:0] a);
    addr = a; ce_n = 0; reg_n = 0; iord_n = 0; step();
  endtask

  task automatic t_reset();
    check("R5 io_mode", io_mode, 0);
    check("R5 ack_n", ack_n, 1);
    check("R5 port16_n", port16_n, 1);
    check("R5 intreq_n", intreq_n, 1);
  endtask

  task automatic t_decode();
    indep_io = 0;
    io_read(10'h305); check("R1 in window", ack_n, 0);
    io_read(10'h31F); check("R1 window top", ack_n, 0);
    io_read(10'h320); check("R2 above window", ack_n, 1);
    io_read(10'h2FF); check("R2 below window", ack_n, 1);
    io_read(10'h300); iord_n = 1; step(); check("R4 iord release", ack_n, 1);
    io_read(10'h300); ce_n = 1; step(); check("R4 ce release", ack_n, 1);
    io_read(10'h300); reg_n = 1; step(); check("R4 reg release", ack_n, 1);
    indep_io = 1;
    io_read(10'h0A5); check("R3 indep any addr", ack_n, 0);
    indep_io = 0; step(); check("R2 indep off", ack_n, 1);
    idle();
  endtask

  task automatic t_mem_mode();
    word_ok = 1; irq_pending = 1;
    io_read(10'h304); check("R6 wp high", port16_n, 1);
    check("R6 ready high", intreq_n, 1);
    idle();
    addr = CFG + 1; ce_n = 0; reg_n = 0; we_n = 0; step(); idle(); step();
    check("R7 near miss no switch", io_mode, 0);
    check("R6 still ready", intreq_n, 1);
  endtask

  task automatic t_switch();
    addr = CFG; ce_n = 0; reg_n = 0; we_n = 0; step();
    check("R7 cfg write no ack", ack_n, 1);
    idle(); step();
    check("R7 io_mode set", io_mode, 1);
    check("R9 irq asserted", intreq_n, 0);
    irq_pending = 0; step(); check("R9 irq released", intreq_n, 1);
    irq_pending = 1; step(); check("R9 irq again", intreq_n, 0);
    irq_pending = 0;
    word_ok = 1; io_read(10'h310); check("R8 word", port16_n, 0);
    word_ok = 0; step(); check("R8 byte only", port16_n, 1);
    word_ok = 1; io_read(10'h340); check("R8 outside window", port16_n, 1);
    idle(); check("R8 idle", port16_n, 1);
    repeat (3) step(); check("R7 sticky", io_mode, 1);
  endtask

  task automatic t_rereset();
    rst_n = 0; step(); rst_n = 1; irq_pending = 1; step();
    check("R5 back to memory mode", io_mode, 0);
    check("R6 after reset", intreq_n, 1);
    irq_pending = 0;
  endtask

  initial begin
    #4ms;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) step();
    rst_n = 1; step();
    t_reset();
    t_decode();
    t_mem_mode();
    t_switch();
    t_rereset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule